// File: doc/BRIEF.md
# UART Idle and Break Line Monitor

This block sits next to a UART receiver. It watches the stream of finished characters for two line conditions. The first is a run of idle characters, meaning all data bits are one and the stop bit is valid. When the run reaches a programmed length during an open receive session, the block raises a single-cycle idle-timeout event. Any other character clears the run. A programmed length of zero turns the timeout off.

The second condition is a break, meaning all data bits are zero and the stop bit is missing. The block counts how many breaks have started and measures how long each break lasts, in character times. It publishes that length only when the break ends. The end of a break is the first cycle in which the sampled line level reads one, or the arrival of a character that is not a break.

When a break starts while a receive session is open, the block pulses a session-close request. It then holds a break-during-reception flag until the break ends. Downstream logic uses these pulses to close buffers and raise interrupts. That logic is outside this block.

Top module: `uart_line_monitor`

Two state machines do the work:

- **Idle tracker**
  - States: `IDL_COUNT` and `IDL_HELD`.
  - Transitions:
    - count-reached moves `IDL_COUNT` to `IDL_HELD`.
    - non-idle-char moves either state back to `IDL_COUNT` and clears the run.
    - idle-char in `IDL_HELD` stays in `IDL_HELD`.
- **Break tracker**
  - States: `BRK_WAIT` and `BRK_ON`.
  - Transitions:
    - break-start moves `BRK_WAIT` to `BRK_ON`.
    - break-grow stays in `BRK_ON`.
    - break-finish moves `BRK_ON` to `BRK_WAIT`, on a line one or on a non-break character.

All outputs are registered. Each one changes on the clock edge at which its triggering input is sampled.

## Requirements
- R1: A character with `chr_valid` high, all data bits one and `chr_frame_err` low is an idle character. When the run of consecutive idle characters reaches `max_idle` (nonzero) and `rx_active` is high in that cycle, `idle_timeout` pulses high for exactly one cycle.
- R2: If `rx_active` is low when the run reaches `max_idle`, no `idle_timeout` is produced. The run still counts as spent, so later idle characters do not fire even if `rx_active` rises.
- R3: Any valid character that is not an idle character clears the idle run. This includes a character with a framing error and nonzero data.
- R4: With `max_idle` equal to zero, `idle_timeout` never fires, however long the idle run.
- R5: After the timeout has been reached, further idle characters produce no new `idle_timeout` until a non-idle character restarts the run.
- R6: A character with `chr_valid` high, all data bits zero and `chr_frame_err` high is a break character. The first break character after a finished break starts a new break and adds one to `brk_count`. The count saturates at all ones. Later break characters of the same break do not change it.
- R7: `brk_len` changes only in the cycle `brk_end` is high. It then takes the number of break characters in the finished break, saturating at all ones.
- R8: While a break is in progress, `brk_end` pulses high for one cycle after the first cycle `rx_line` is one, or after a valid non-break character, whichever comes first. `rx_line` has no effect when no break is in progress.
- R9: If `rx_active` is high when a break starts, `sess_close` pulses for one cycle and `brk_in_rx` goes high until the break ends. If `rx_active` is low, neither is asserted.
- R10: After reset, `idle_timeout`, `brk_count`, `brk_len`, `brk_end`, `brk_in_rx` and `sess_close` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chr_valid | input | 1 | One-cycle strobe: a character has been completed |
| chr_data | input | DATA_W | Data bits of the completed character |
| chr_frame_err | input | 1 | The character had no stop bit |
| rx_line | input | 1 | Sampled receive line level |
| rx_active | input | 1 | A receive session is open |
| max_idle | input | IDLE_W | Idle-run length that triggers the timeout; zero disables it |
| idle_timeout | output | 1 | Idle-timeout event pulse |
| brk_count | output | CNT_W | Number of breaks started, saturating |
| brk_len | output | LEN_W | Length of the last finished break in characters |
| brk_end | output | 1 | Break-finished event pulse |
| brk_in_rx | output | 1 | Break arrived during an open receive session |
| sess_close | output | 1 | Request to end the current receive session |

## Verification
The hardest states to reach from the ports are the two saturation points.

- **Break length at its ceiling.** Reaching the top of `brk_len` needs one unbroken break of more than 255 characters. The bench streams 300 break characters with the line held low, then releases the line.
- **Break counter at its ceiling.** The bench builds the block with a 4-bit break counter. It repeats short breaks until the counter is full, then confirms that one more break leaves it unchanged.
- **Spent idle run with a late session.** The bench lets the run reach its limit with no session open, then opens the session. No late event may follow.

// File: rtl/lmon_pkg.sv
package lmon_pkg;

    // Idle-run tracker states
    typedef enum logic {
        IDL_COUNT = 1'b0,
        IDL_HELD  = 1'b1
    } idle_st_e;

    // Break tracker states
    typedef enum logic {
        BRK_WAIT = 1'b0,
        BRK_ON   = 1'b1
    } brk_st_e;

endpackage

// File: rtl/lmon_char_class.sv
module lmon_char_class #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              frame_err,
    output logic              is_idle,
    output logic              is_break
);

    // Idle: every data bit high and a proper stop bit.
    // Break: every data bit low and no stop bit.
    always_comb begin
        is_idle  = (&data) && !frame_err;
        is_break = (~|data) && frame_err;
    end

endmodule

// File: rtl/lmon_idle_tracker.sv
module lmon_idle_tracker
    import lmon_pkg::*;
#(
    parameter int IDLE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic              is_idle,
    input  logic [IDLE_W-1:0] max_idle,
    input  logic              rx_active,
    output logic              idle_timeout
);

    localparam int RUN_W = IDLE_W + 1;

    idle_st_e          st_q, st_d;
    logic [IDLE_W-1:0] run_q, run_d;
    logic              fire_d;
    logic [RUN_W-1:0]  run_inc;
    logic              limit_on;

    always_comb begin
        run_inc  = {1'b0, run_q} + {{IDLE_W{1'b0}}, 1'b1};
        limit_on = (max_idle != '0);
    end

    // Next-state and next-output decisions
    always_comb begin
        st_d   = st_q;
        run_d  = run_q;
        fire_d = 1'b0;
        if (chr_valid) begin
            if (!is_idle) begin
                // non-idle-char: restart the run
                st_d  = IDL_COUNT;
                run_d = '0;
            end else begin
                unique case (st_q)
                    IDL_COUNT: begin
                        if (limit_on) begin
                            if (run_inc >= {1'b0, max_idle}) begin
                                // count-reached
                                st_d   = IDL_HELD;
                                run_d  = max_idle;
                                fire_d = rx_active;
                            end else begin
                                run_d = run_inc[IDLE_W-1:0];
                            end
                        end
                    end
                    IDL_HELD: begin
                        // idle-char while held: no change
                        st_d = IDL_HELD;
                    end
                    default: st_d = IDL_COUNT;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= IDL_COUNT;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_timeout <= 1'b0;
        end else begin
            idle_timeout <= fire_d;
        end
    end

    // R1
    fire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_timeout |-> ($past(chr_valid) && $past(is_idle) && $past(rx_active)));

    // R4
    fire_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_timeout |-> ($past(max_idle) != '0));

    // R5
    fire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_timeout |=> !idle_timeout);

endmodule

// File: rtl/lmon_break_tracker.sv
module lmon_break_tracker
    import lmon_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chr_valid,
    input  logic             is_break,
    input  logic             rx_line,
    input  logic             rx_active,
    output logic [CNT_W-1:0] brk_count,
    output logic [LEN_W-1:0] brk_len,
    output logic             brk_end,
    output logic             brk_in_rx,
    output logic             sess_close
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    brk_st_e          st_q, st_d;
    logic [LEN_W-1:0] run_q, run_d;
    logic             start_now, finish_now, grow_now;

    // Transition conditions
    always_comb begin
        start_now  = (st_q == BRK_WAIT) && chr_valid && is_break;
        finish_now = (st_q == BRK_ON) && (rx_line || (chr_valid && !is_break));
        grow_now   = (st_q == BRK_ON) && !finish_now && chr_valid && is_break;
    end

    always_comb begin
        st_d  = st_q;
        run_d = run_q;
        unique case (st_q)
            BRK_WAIT: begin
                if (start_now) begin
                    // break-start
                    st_d  = BRK_ON;
                    run_d = {{(LEN_W-1){1'b0}}, 1'b1};
                end
            end
            BRK_ON: begin
                if (finish_now) begin
                    // break-finish
                    st_d = BRK_WAIT;
                end else if (grow_now && run_q != LEN_MAX) begin
                    // break-grow
                    run_d = run_q + 1'b1;
                end
            end
            default: st_d = BRK_WAIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= BRK_WAIT;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            run_q <= run_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            brk_count  <= '0;
            brk_len    <= '0;
            brk_end    <= 1'b0;
            brk_in_rx  <= 1'b0;
            sess_close <= 1'b0;
        end else begin
            brk_end    <= finish_now;
            sess_close <= start_now && rx_active;
            if (start_now && brk_count != CNT_MAX) begin
                brk_count <= brk_count + 1'b1;
            end
            if (finish_now) begin
                brk_len   <= run_q;
                brk_in_rx <= 1'b0;
            end else if (start_now && rx_active) begin
                brk_in_rx <= 1'b1;
            end
        end
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_count != $past(brk_count)) |-> (brk_count == $past(brk_count) + 1'b1));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_len != $past(brk_len)) |-> brk_end);

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        brk_end |=> !brk_end);

    // R9
    rx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brk_in_rx) |-> sess_close);

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor #(
    parameter int DATA_W = 8,
    parameter int IDLE_W = 16,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chr_valid,
    input  logic [DATA_W-1:0] chr_data,
    input  logic              chr_frame_err,
    input  logic              rx_line,
    input  logic              rx_active,
    input  logic [IDLE_W-1:0] max_idle,
    output logic              idle_timeout,
    output logic [CNT_W-1:0]  brk_count,
    output logic [LEN_W-1:0]  brk_len,
    output logic              brk_end,
    output logic              brk_in_rx,
    output logic              sess_close
);

    logic is_idle;
    logic is_break;

    lmon_char_class #(.DATA_W(DATA_W)) class_i (
        .data      (chr_data),
        .frame_err (chr_frame_err),
        .is_idle   (is_idle),
        .is_break  (is_break)
    );

    lmon_idle_tracker #(.IDLE_W(IDLE_W)) idle_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .chr_valid    (chr_valid),
        .is_idle      (is_idle),
        .max_idle     (max_idle),
        .rx_active    (rx_active),
        .idle_timeout (idle_timeout)
    );

    lmon_break_tracker #(.CNT_W(CNT_W), .LEN_W(LEN_W)) brk_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chr_valid  (chr_valid),
        .is_break   (is_break),
        .rx_line    (rx_line),
        .rx_active  (rx_active),
        .brk_count  (brk_count),
        .brk_len    (brk_len),
        .brk_end    (brk_end),
        .brk_in_rx  (brk_in_rx),
        .sess_close (sess_close)
    );

    // R3
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_idle && is_break));

endmodule

// File: tb/uart_line_monitor_tb_top.sv
module uart_line_monitor_tb_top;

    localparam int DATA_W = 8;
    localparam int IDLE_W = 16;
    localparam int CNT_W  = 4;
    localparam int LEN_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              chr_valid = 1'b0;
    logic [DATA_W-1:0] chr_data = '0;
    logic              chr_frame_err = 1'b0;
    logic              rx_line = 1'b1;
    logic              rx_active = 1'b0;
    logic [IDLE_W-1:0] max_idle = '0;
    logic              idle_timeout;
    logic [CNT_W-1:0]  brk_count;
    logic [LEN_W-1:0]  brk_len;
    logic              brk_end;
    logic              brk_in_rx;
    logic              sess_close;

    int total = 0;
    int bad = 0;
    int exp_cnt = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_line_monitor #(
        .DATA_W(DATA_W), .IDLE_W(IDLE_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .chr_valid(chr_valid), .chr_data(chr_data),
        .chr_frame_err(chr_frame_err), .rx_line(rx_line), .rx_active(rx_active),
        .max_idle(max_idle), .idle_timeout(idle_timeout), .brk_count(brk_count),
        .brk_len(brk_len), .brk_end(brk_end), .brk_in_rx(brk_in_rx),
        .sess_close(sess_close)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one character for one cycle; outputs are valid on return.
    task automatic send(input logic [DATA_W-1:0] d, input logic fe);
        @(negedge clk);
        chr_valid = 1'b1;
        chr_data = d;
        chr_frame_err = fe;
        @(negedge clk);
        chr_valid = 1'b0;
    endtask

    task automatic send_idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            send('1, 1'b0);
            check(req, int'(idle_timeout), 0);
        end
    endtask

    task automatic bump_cnt();
        if (exp_cnt < 15) exp_cnt++;
    endtask

    task automatic finish_break(input int exp_len, input string req);
        @(negedge clk);
        rx_line = 1'b1;
        @(negedge clk);
        check(req, int'(brk_end), 1);
        check(req, int'(brk_len), exp_len);
        check("R9", int'(brk_in_rx), 0);
        @(negedge clk);
        check(req, int'(brk_end), 0);
    endtask

    task automatic t_reset();
        check("R10", int'(idle_timeout), 0);
        check("R10", int'(brk_count), 0);
        check("R10", int'(brk_len), 0);
        check("R10", int'(brk_end), 0);
        check("R10", int'(brk_in_rx), 0);
        check("R10", int'(sess_close), 0);
    endtask

    task automatic t_idle_basic();
        rx_active = 1'b1;
        max_idle = 3;
        send(8'h41, 1'b0);
        send_idle(2, "R1");
        send('1, 1'b0);
        check("R1", int'(idle_timeout), 1);
        @(negedge clk);
        check("R1", int'(idle_timeout), 0);
    endtask

    task automatic t_idle_hold();
        send_idle(4, "R5");
        send(8'h5a, 1'b0);
        send_idle(2, "R5");
        send('1, 1'b0);
        check("R5", int'(idle_timeout), 1);
    endtask

    task automatic t_idle_reset();
        send(8'h00, 1'b0);
        send_idle(2, "R3");
        send(8'h55, 1'b0);
        send_idle(2, "R3");
        send(8'h12, 1'b1);
        send_idle(2, "R3");
        send('1, 1'b0);
        check("R3", int'(idle_timeout), 1);
    endtask

    task automatic t_idle_inactive();
        rx_active = 1'b0;
        max_idle = 2;
        send(8'h33, 1'b0);
        send_idle(2, "R2");
        rx_active = 1'b1;
        send_idle(3, "R2");
    endtask

    task automatic t_idle_disabled();
        max_idle = 0;
        send(8'h33, 1'b0);
        send_idle(20, "R4");
    endtask

    task automatic t_break_basic();
        rx_active = 1'b0;
        rx_line = 1'b0;
        send(8'h00, 1'b1);
        bump_cnt();
        check("R6", int'(brk_count), exp_cnt);
        check("R9", int'(sess_close), 0);
        check("R9", int'(brk_in_rx), 0);
        send(8'h00, 1'b1);
        send(8'h00, 1'b1);
        check("R6", int'(brk_count), exp_cnt);
        check("R7", int'(brk_len), 0);
        check("R8", int'(brk_end), 0);
        finish_break(3, "R8");
        // rx_line toggling with no break in progress does nothing
        rx_line = 1'b0;
        @(negedge clk);
        rx_line = 1'b1;
        @(negedge clk);
        check("R8", int'(brk_end), 0);
        check("R7", int'(brk_len), 3);
    endtask

    task automatic t_break_rx();
        rx_active = 1'b1;
        rx_line = 1'b0;
        send(8'h00, 1'b1);
        bump_cnt();
        check("R9", int'(sess_close), 1);
        check("R9", int'(brk_in_rx), 1);
        @(negedge clk);
        check("R9", int'(sess_close), 0);
        check("R9", int'(brk_in_rx), 1);
        send(8'h00, 1'b1);
        check("R6", int'(brk_count), exp_cnt);
        finish_break(2, "R7");
        rx_active = 1'b0;
    endtask

    task automatic t_break_char_end();
        rx_line = 1'b0;
        send(8'h00, 1'b1);
        bump_cnt();
        send(8'h00, 1'b0);
        check("R8", int'(brk_end), 1);
        check("R7", int'(brk_len), 1);
        @(negedge clk);
        check("R8", int'(brk_end), 0);
        rx_line = 1'b1;
    endtask

    task automatic t_break_len_sat();
        rx_line = 1'b0;
        for (int i = 0; i < 300; i++) send(8'h00, 1'b1);
        bump_cnt();
        check("R7", int'(brk_len), 1);
        finish_break(255, "R7");
    endtask

    task automatic t_break_cnt_sat();
        for (int k = 0; k < 16; k++) begin
            rx_line = 1'b0;
            send(8'h00, 1'b1);
            bump_cnt();
            rx_line = 1'b1;
            @(negedge clk);
            @(negedge clk);
        end
        check("R6", int'(brk_count), 15);
        check("R6", int'(brk_count), exp_cnt);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_basic();
        t_idle_hold();
        t_idle_reset();
        t_idle_inactive();
        t_idle_disabled();
        t_break_basic();
        t_break_rx();
        t_break_char_end();
        t_break_len_sat();
        t_break_cnt_sat();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule